// File: doc/BRIEF.md
# Phase Count Strap Detector

This block decides how many phases a multiphase buck controller runs. It does not read a configuration register. Instead it reads back two of the PWM output pins while the converter starts up. A board builds the two- or three-phase configuration by tying the fourth PWM pin, or both the third and fourth PWM pins, to the supply rail. Any pin left unconnected is held low by an on-chip pull-down sink.

While the block is disabled and before ramp-up, the pull-downs on both strap pins are enabled. The first two PWM outputs are forced low. The start-up sequencer raises a window strobe during the first cycles of the ramp. The block samples the two comparator results on the last cycle of that window and latches a phase count. It then removes the pull-downs, turns on the drivers of the strap pins that read low, and leaves the strap pins that read high in high impedance. The count stays latched until enable falls.

The controller is a four-state machine. IDLE moves to ARMED when enable rises. ARMED moves to DETECT when the strobe rises. DETECT moves back to ARMED when the strobe drops early. DETECT moves to RUN when the window completes. ARMED moves directly to RUN when the window is only one cycle long. From any state, enable low leads to IDLE.

Top module: `phase_strap_detector`

## Requirements
- R1: While reset is asserted, and on the cycle after any clock edge at which en_i is low, the outputs are as follows. phase_cnt_o is 4. pd_en_o is 2'b11. oe_o is 2'b00. force_low_o is 2'b11. strap_fault_o is 0.
- R2: Pin vectors use one bit order. In strap_hi_i, pd_en_o and oe_o, bit 0 is the third PWM pin and bit 1 is the fourth PWM pin. In force_low_o, bit 0 is the first PWM pin and bit 1 is the second PWM pin. From the time en_i rises until the window completes, the outputs keep the R1 values.
- R3: The strap levels are sampled at the clock edge of the WIN_CYCLES-th consecutive cycle in which win_i is high (default 4). Levels on earlier window cycles have no effect on the result. The new configuration appears on the outputs after that edge.
- R4: phase_cnt_o is a binary value. Neither strap pin high gives 4. Only the fourth pin high gives 3. Both strap pins high gives 2.
- R5: The strap with the third pin high and the fourth pin low is invalid. It yields phase_cnt_o = 4 with strap_fault_o = 1.
- R6: Once configured, pd_en_o is 2'b00 and force_low_o is 2'b00. oe_o[0] is 1 when the count is at least 3, and oe_o[1] is 1 when the count is 4.
- R7: If win_i drops before the window completes, the partial window is discarded. The next strobe starts a full new window.
- R8: Once configured, changes on win_i and strap_hi_i have no effect until en_i goes low.
- R9: After en_i goes low and high again, a new window performs a fresh detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable |
| win_i | input | 1 | Detection window strobe from the start-up sequencer |
| strap_hi_i | input | 2 | Comparator results: strap pin above threshold (bit 0 third pin, bit 1 fourth pin) |
| phase_cnt_o | output | 3 | Latched phase count (2, 3 or 4) |
| pd_en_o | output | 2 | Pull-down sink enable per strap pin |
| oe_o | output | 2 | Driver enable per strap pin (0 = high impedance) |
| force_low_o | output | 2 | Hold the first and second PWM outputs low |
| strap_fault_o | output | 1 | Invalid strap was read |

## Verification
The bench changes the comparator levels on the cycles before the last window cycle. A design that samples early, or that ORs the levels over the whole window, would latch the wrong count. Windows are also cut short before the real window arrives. A design that keeps its partial count would configure too early, drop its pull-downs and release the forced-low outputs. After configuration, the bench pulses the strobe again and wiggles the straps. A design that re-samples would change its drivers while running. The invalid strap combination is forced, which catches a decoder that reports three or two phases for it.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int STRAP_PINS = 2;
    localparam int CNT_W      = 3;

    localparam logic [CNT_W-1:0] CNT_TWO   = 3'd2;
    localparam logic [CNT_W-1:0] CNT_THREE = 3'd3;
    localparam logic [CNT_W-1:0] CNT_FOUR  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_DETECT,
        ST_RUN
    } psd_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } psd_cfg_t;

    localparam psd_cfg_t CFG_DEFAULT = '{cnt: CNT_FOUR, fault: 1'b0};

endpackage

// File: rtl/psd_win_counter.sv
module psd_win_counter #(
    parameter int WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic win_i,
    output logic done_o
);
    localparam int WCW = (WIN_CYCLES < 2) ? 1 : $clog2(WIN_CYCLES + 1);
    localparam logic [WCW-1:0] LAST = WCW'(WIN_CYCLES - 1);

    logic [WCW-1:0] wcnt_q;

    // counts consecutive strobe cycles while armed or detecting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (active_i && win_i && (wcnt_q != LAST)) begin
            wcnt_q <= wcnt_q + 1'b1;
        end else begin
            wcnt_q <= '0;
        end
    end

    assign done_o = active_i && win_i && (wcnt_q == LAST);

endmodule

// File: rtl/psd_strap_decode.sv
module psd_strap_decode
    import psd_pkg::*;
(
    input  logic [STRAP_PINS-1:0] strap_hi_i,
    output psd_cfg_t              cfg_o
);
    always_comb begin
        unique case (strap_hi_i)
            2'b00:   cfg_o = '{cnt: CNT_FOUR,  fault: 1'b0};
            2'b10:   cfg_o = '{cnt: CNT_THREE, fault: 1'b0};
            2'b11:   cfg_o = '{cnt: CNT_TWO,   fault: 1'b0};
            default: cfg_o = '{cnt: CNT_FOUR,  fault: 1'b1};
        endcase
    end

endmodule

// File: rtl/psd_cfg_latch.sv
module psd_cfg_latch
    import psd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear_i,
    input  logic     load_i,
    input  psd_cfg_t cfg_i,
    output psd_cfg_t cfg_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o <= CFG_DEFAULT;
        end else if (clear_i) begin
            cfg_o <= CFG_DEFAULT;
        end else if (load_i) begin
            cfg_o <= cfg_i;
        end
    end

endmodule

// File: rtl/phase_strap_detector.sv
module phase_strap_detector
    import psd_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       win_i,
    input  logic [1:0] strap_hi_i,
    output logic [2:0] phase_cnt_o,
    output logic [1:0] pd_en_o,
    output logic [1:0] oe_o,
    output logic [1:0] force_low_o,
    output logic       strap_fault_o
);
    psd_state_e state_q, state_d;
    logic       win_active;
    logic       win_done;
    logic       cfg_load;
    logic       cfg_clear;
    psd_cfg_t   cfg_dec;
    psd_cfg_t   cfg_q;

    assign win_active = en_i && ((state_q == ST_ARMED) || (state_q == ST_DETECT));
    assign cfg_load   = en_i && win_done;
    assign cfg_clear  = !en_i;

    psd_win_counter #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (win_active),
        .win_i    (win_i),
        .done_o   (win_done)
    );

    psd_strap_decode u_dec (
        .strap_hi_i (strap_hi_i),
        .cfg_o      (cfg_dec)
    );

    psd_cfg_latch u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cfg_clear),
        .load_i  (cfg_load),
        .cfg_i   (cfg_dec),
        .cfg_o   (cfg_q)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_ARMED;
                ST_ARMED: begin
                    if (win_done)   state_d = ST_RUN;
                    else if (win_i) state_d = ST_DETECT;
                end
                ST_DETECT: begin
                    if (!win_i)       state_d = ST_ARMED;
                    else if (win_done) state_d = ST_RUN;
                end
                ST_RUN:    state_d = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        phase_cnt_o   = CNT_FOUR;
        strap_fault_o = 1'b0;
        pd_en_o       = 2'b11;
        oe_o          = 2'b00;
        force_low_o   = 2'b11;
        unique case (state_q)
            ST_IDLE, ST_ARMED, ST_DETECT: ;
            ST_RUN: begin
                phase_cnt_o   = cfg_q.cnt;
                strap_fault_o = cfg_q.fault;
                pd_en_o       = 2'b00;
                force_low_o   = 2'b00;
                oe_o[0]       = (cfg_q.cnt >= CNT_THREE);
                oe_o[1]       = (cfg_q.cnt == CNT_FOUR);
            end
        endcase
    end

endmodule

// File: rtl/psd_checker.sv
module psd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       win_i,
    input logic [1:0] strap_hi_i,
    input logic [2:0] phase_cnt_o,
    input logic [1:0] pd_en_o,
    input logic [1:0] oe_o,
    input logic [1:0] force_low_o,
    input logic       strap_fault_o
);
    // R1: disable returns to the safe defaults on the next cycle
    a_r1_disable_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (phase_cnt_o == 3'd4 && pd_en_o == 2'b11 && oe_o == 2'b00
                   && force_low_o == 2'b11 && !strap_fault_o));

    // R6: a pin is never driven while its sink is on
    a_r6_no_drive_with_sink: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o & pd_en_o) == 2'b00);

    // R2: forced-low outputs are released only together with the sinks
    a_r2_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        (force_low_o != 2'b11) |-> (pd_en_o == 2'b00 && force_low_o == 2'b00));

    // R4: count is always a legal value
    a_r4_legal_count: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt_o == 3'd2 || phase_cnt_o == 3'd3 || phase_cnt_o == 3'd4));

    // R5: fault implies four-phase operation
    a_r5_fault_four: assert property (@(posedge clk) disable iff (!rst_n)
        strap_fault_o |-> phase_cnt_o == 3'd4);

    // R6: driven pins match count once running
    a_r6_oe_count: assert property (@(posedge clk) disable iff (!rst_n)
        (force_low_o == 2'b00) |-> ($countones(oe_o) + 2 == int'(phase_cnt_o)));

    // R8: configuration holds while running and enabled
    a_r8_hold_config: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && force_low_o == 2'b00 && $past(force_low_o) == 2'b00)
        |-> ($stable(phase_cnt_o) && $stable(oe_o) && $stable(strap_fault_o)));

endmodule

bind phase_strap_detector psd_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .win_i         (win_i),
    .strap_hi_i    (strap_hi_i),
    .phase_cnt_o   (phase_cnt_o),
    .pd_en_o       (pd_en_o),
    .oe_o          (oe_o),
    .force_low_o   (force_low_o),
    .strap_fault_o (strap_fault_o)
);

// File: tb/phase_strap_detector_tb.sv
module phase_strap_detector_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       win_i = 1'b0;
    logic [1:0] strap_hi_i = 2'b00;
    logic [2:0] phase_cnt_o;
    logic [1:0] pd_en_o;
    logic [1:0] oe_o;
    logic [1:0] force_low_o;
    logic       strap_fault_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_strap_detector #(.WIN_CYCLES(WIN)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en_i),
        .win_i         (win_i),
        .strap_hi_i    (strap_hi_i),
        .phase_cnt_o   (phase_cnt_o),
        .pd_en_o       (pd_en_o),
        .oe_o          (oe_o),
        .force_low_o   (force_low_o),
        .strap_fault_o (strap_fault_o)
    );

    // packed view: {fault, cnt[2:0], oe[1:0], pd[1:0], force[1:0]}
    function automatic logic [9:0] idle_vec();
        return {1'b0, 3'd4, 2'b00, 2'b11, 2'b11};
    endfunction

    function automatic logic [9:0] run_vec(input logic [1:0] s);
        logic [2:0] c;
        logic       f;
        f = 1'b0;
        if (s == 2'b00)      c = 3'd4;
        else if (s == 2'b10) c = 3'd3;
        else if (s == 2'b11) c = 3'd2;
        else begin c = 3'd4; f = 1'b1; end
        return {f, c, (c == 3'd4), (c >= 3'd3), 2'b00, 2'b00};
    endfunction

    function automatic logic [9:0] act_vec();
        return {strap_fault_o, phase_cnt_o, oe_o, pd_en_o, force_low_o};
    endfunction

    task automatic check(input string req, input logic [9:0] exp);
        logic [9:0] a;
        a = act_vec();
        checks++;
        if (a !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, a, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // full window, random levels before last cycle, final levels s
    task automatic window(input logic [1:0] s, input string req);
        for (int i = 0; i < WIN; i++) begin
            win_i = 1'b1;
            strap_hi_i = (i == WIN-1) ? s : 2'($urandom);
            cyc();
            if (i < WIN-1) check("R2", idle_vec());
        end
        win_i = 1'b0;
        strap_hi_i = 2'($urandom);
        check(req, run_vec(s));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #(CLK_PERIOD * 2);
        check("R1 reset", idle_vec());
        cyc();
        rst_n = 1'b1;
        cyc();
        check("R1 disabled", idle_vec());

        // R2: enabled but no strobe keeps defaults
        en_i = 1'b1;
        strap_hi_i = 2'b11;
        repeat (3) begin cyc(); check("R2 armed", idle_vec()); end

        // R4 four phases, earlier noise ignored (R3)
        window(2'b00, "R4 four / R3");
        // R8: strobe and straps ignored while running
        for (int k = 0; k < 6; k++) begin
            win_i = 1'b1; strap_hi_i = 2'(k); cyc();
            check("R8 ignored", run_vec(2'b00));
        end
        win_i = 1'b0;

        // R1/R9: disable then redetect three phases
        en_i = 1'b0; cyc(); check("R1 en low", idle_vec());
        en_i = 1'b1; cyc(); check("R9 re-armed", idle_vec());
        window(2'b10, "R4 three / R9");

        en_i = 1'b0; cyc(); en_i = 1'b1; cyc();
        window(2'b11, "R4 two / R6");

        en_i = 1'b0; cyc(); en_i = 1'b1; cyc();
        window(2'b01, "R5 invalid");

        // R7: aborted partial window
        en_i = 1'b0; cyc(); en_i = 1'b1; cyc();
        for (int i = 0; i < WIN-1; i++) begin
            win_i = 1'b1; strap_hi_i = 2'b11; cyc();
            check("R7 partial", idle_vec());
        end
        win_i = 1'b0; cyc(); check("R7 aborted", idle_vec());
        window(2'b10, "R7 restart");

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [1:0] s;
            int abort_len;
            s = 2'($urandom);
            en_i = 1'b0; cyc(); check("R1 rand", idle_vec());
            en_i = 1'b1;
            repeat (1 + ($urandom % 3)) cyc();
            abort_len = $urandom % WIN;
            for (int i = 0; i < abort_len; i++) begin
                win_i = 1'b1; strap_hi_i = 2'($urandom); cyc();
            end
            win_i = 1'b0; cyc();
            check("R7 rand", idle_vec());
            window(s, "R4 rand");
            for (int k = 0; k < 2; k++) begin
                win_i = $urandom % 2; strap_hi_i = 2'($urandom); cyc();
                check("R8 rand", run_vec(s));
            end
            win_i = 1'b0;
        end

        finish_run();
    end

endmodule